// File: doc/BRIEF.md
# Sized Integer Add/Subtract Unit with Condition Codes

This unit handles the add, subtract, compare and negate steps of a processor datapath that has several operand sizes. Each valid request carries an operation code, a size code, two 32-bit operands, a 3-bit quick constant and a flag that says the destination is an address register. One clock later the unit returns the value to write back, with a write strobe. It also returns the five condition bits (extend, negative, zero, overflow, carry). Each condition bit has its own update strobe, so the register file and the status register can apply the results without any further decoding.

Only the low 8, 16 or 32 bits selected by the size code take part in the arithmetic. Carry, overflow and sign are taken at the top bit of that slice. At byte and word size the upper bits of the destination operand pass through unchanged. Quick operations aimed at an address register always work on all 32 bits and leave the condition bits alone. Combinations that make no sense raise a one-cycle illegal pulse, and nothing is written.

Top module: `sized_cc_alu`

## Requirements
- R1: The results appear exactly one clock after a cycle with `in_valid` high, marked by `out_valid`. In any cycle where `out_valid` is low, every write strobe and `illegal_op` are low.
- R2: `op_sel` 0 (add) gives destination plus source at the selected size. C and X both equal the carry out of the size's top bit.
- R3: `op_sel` 1 (subtract) gives destination minus source. C and X both equal the borrow.
- R4: `op_sel` 2 (compare) computes destination minus source and updates N, Z, V and C. It writes no result and does not update X.
- R5: `op_sel` 3 (negate) gives zero minus the destination operand. C and X are set exactly when that operand is nonzero at the selected size.
- R6: `op_sel` 4 (quick add) and 5 (quick subtract) use the quick field as a constant from 1 to 7, and code 000 stands for 8.
- R7: Size code 00 is byte, 01 is word and 10 is long. V is set when the signed result does not fit the size. N is the top bit of the result at that size.
- R8: Z is set when the result, cut to the selected size, is all zeros.
- R9: A byte or word write replaces only the low 8 or 16 bits. The remaining bits of `result` equal those of `dst_opnd`.
- R10: A quick add or subtract with `addr_dst` set and word or long size works on all 32 bits. It writes the result and updates no condition bit.
- R11: Any of the following is illegal: a byte-size quick operation with `addr_dst` set, a negate with `addr_dst` set, size code 11, or `op_sel` 6 or 7. An illegal request pulses `illegal_op`, writes no result and updates no condition bit.
- R12: For add, subtract and compare, `addr_dst` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 neg, 4 quick add, 5 quick sub) |
| size_sel | input | 2 | Operand size (00 byte, 01 word, 10 long) |
| src_opnd | input | 32 | Source operand |
| dst_opnd | input | 32 | Destination operand (negate operand) |
| quick_imm | input | 3 | Quick constant, 000 means 8 |
| addr_dst | input | 1 | Destination is an address register |
| out_valid | output | 1 | Results valid this cycle |
| result | output | 32 | Value to write back, upper bits merged from `dst_opnd` |
| result_we | output | 1 | Write strobe for `result` |
| flag_x | output | 1 | Extend bit value |
| flag_n | output | 1 | Negative bit value |
| flag_z | output | 1 | Zero bit value |
| flag_v | output | 1 | Overflow bit value |
| flag_c | output | 1 | Carry/borrow bit value |
| x_we | output | 1 | Update strobe for extend |
| n_we | output | 1 | Update strobe for negative |
| z_we | output | 1 | Update strobe for zero |
| v_we | output | 1 | Update strobe for overflow |
| c_we | output | 1 | Update strobe for carry |
| illegal_op | output | 1 | One-cycle pulse for an illegal request |

## Verification
The bench targets six corner cases:
- Carry and overflow taken at the wrong bit: 0x7F+1 at byte size and 0x80000000-1 at long size would show either V missing or a carry leaking into bit 8.
- Quick code 000: if it were read as zero, the destination would come back unchanged.
- Word-size quick add to an address register: crossing 0xFFFF would lose the carry into the upper half, or the update strobes would fire when they must not.
- Compare touching X: this would show up as `x_we` high.
- Negate of zero and of the most negative value: this checks the carry rule and the overflow rule.
- Illegal combinations: a faulty design would still raise a write strobe.

A pseudorandom stream of back-to-back requests is then compared against a wide-integer model, which exercises the rules mixed together.

// File: rtl/sized_cc_alu_pkg.sv
`timescale 1ns/1ps
package sized_cc_alu_pkg;

  typedef logic [2:0] alu_op_t;
  localparam alu_op_t OP_ADD  = 3'd0;
  localparam alu_op_t OP_SUB  = 3'd1;
  localparam alu_op_t OP_CMP  = 3'd2;
  localparam alu_op_t OP_NEG  = 3'd3;
  localparam alu_op_t OP_QADD = 3'd4;
  localparam alu_op_t OP_QSUB = 3'd5;
  localparam alu_op_t OP_LAST = OP_QSUB;

  typedef logic [1:0] alu_size_t;
  localparam alu_size_t SZ_BYTE = 2'b00;
  localparam alu_size_t SZ_WORD = 2'b01;
  localparam alu_size_t SZ_LONG = 2'b10;

  localparam int QUICK_W = 3;
  localparam int QUICK_VAL_W = QUICK_W + 1;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  // Quick field 1..7 stands for itself, 0 stands for 2**QUICK_W.
  function automatic logic [QUICK_VAL_W-1:0] quick_value(input logic [QUICK_W-1:0] code);
    if (code == '0) return QUICK_VAL_W'(1) << QUICK_W;
    return {1'b0, code};
  endfunction

  function automatic logic is_quick(input alu_op_t op);
    return (op == OP_QADD) || (op == OP_QSUB);
  endfunction

  function automatic logic is_subtract(input alu_op_t op);
    return (op == OP_SUB) || (op == OP_CMP) || (op == OP_NEG) || (op == OP_QSUB);
  endfunction

endpackage

// File: rtl/sized_cc_alu_decode.sv
`timescale 1ns/1ps
module sized_cc_alu_decode
  import sized_cc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic              addr_dst,
  input  logic [QUICK_W-1:0] quick_imm,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              do_sub,
  output logic [1:0]        eff_size,
  output logic              writes_result,
  output logic              upd_x,
  output logic              upd_nzvc,
  output logic              op_illegal
);

  logic quick_op;
  logic quick_to_addr;
  logic bad_code;

  assign quick_op      = is_quick(op_sel);
  assign quick_to_addr = quick_op && addr_dst;
  assign bad_code      = (op_sel > OP_LAST) || (size_sel == 2'b11);

  assign op_illegal = bad_code
                   || (quick_to_addr && (size_sel == SZ_BYTE))
                   || ((op_sel == OP_NEG) && addr_dst);

  // Address destinations of quick forms always run on the full width.
  assign eff_size = quick_to_addr ? SZ_LONG : size_sel;
  assign do_sub   = is_subtract(op_sel);

  always_comb begin
    opnd_a = dst_opnd;
    opnd_b = src_opnd;
    if (op_sel == OP_NEG) begin
      opnd_a = '0;
      opnd_b = dst_opnd;
    end else if (quick_op) begin
      opnd_b = {{(DATA_W-QUICK_VAL_W){1'b0}}, quick_value(quick_imm)};
    end
  end

  assign writes_result = !op_illegal && (op_sel != OP_CMP);
  assign upd_nzvc      = !op_illegal && !quick_to_addr;
  assign upd_x         = upd_nzvc && (op_sel != OP_CMP);

endmodule

// File: rtl/sized_cc_alu_addsub.sv
`timescale 1ns/1ps
module sized_cc_alu_addsub
  import sized_cc_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 3
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              do_sub,
  input  logic [1:0]        eff_size,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              ovf_out,
  output logic              neg_out,
  output logic              zero_out
);

  logic [DATA_W-1:0] lane_sum [NUM_LANES];
  logic              lane_c   [NUM_LANES];
  logic              lane_v   [NUM_LANES];
  logic              lane_n   [NUM_LANES];
  logic              lane_z   [NUM_LANES];

  // Signed overflow: operands agree in sign, the result does not.
  function automatic logic sign_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // The adder's carry is inverted on subtract to give a borrow.
  function automatic logic carry_or_borrow(input logic raw_carry, input logic sub);
    return raw_carry ^ sub;
  endfunction

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int LW = 8 << i;
    logic [LW-1:0] b_eff;
    logic [LW:0]   s;
    assign b_eff = do_sub ? ~opnd_b[LW-1:0] : opnd_b[LW-1:0];
    assign s = {1'b0, opnd_a[LW-1:0]} + {1'b0, b_eff} + {{LW{1'b0}}, do_sub};
    assign lane_sum[i] = DATA_W'(s[LW-1:0]);
    assign lane_c[i]   = carry_or_borrow(s[LW], do_sub);
    assign lane_v[i]   = sign_overflow(opnd_a[LW-1], b_eff[LW-1], s[LW-1]);
    assign lane_n[i]   = s[LW-1];
    assign lane_z[i]   = ~|s[LW-1:0];
  end

  always_comb begin
    sum_out   = lane_sum[NUM_LANES-1];
    carry_out = lane_c[NUM_LANES-1];
    ovf_out   = lane_v[NUM_LANES-1];
    neg_out   = lane_n[NUM_LANES-1];
    zero_out  = lane_z[NUM_LANES-1];
    for (int k = 0; k < NUM_LANES; k++) begin
      if (int'(eff_size) == k) begin
        sum_out   = lane_sum[k];
        carry_out = lane_c[k];
        ovf_out   = lane_v[k];
        neg_out   = lane_n[k];
        zero_out  = lane_z[k];
      end
    end
  end

endmodule

// File: rtl/sized_cc_alu_merge.sv
`timescale 1ns/1ps
module sized_cc_alu_merge #(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 3
) (
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [DATA_W-1:0] lane_value,
  input  logic [1:0]        eff_size,
  output logic [DATA_W-1:0] merged
);

  function automatic logic [DATA_W-1:0] lane_mask(input int k);
    return {DATA_W{1'b1}} >> (DATA_W - (8 << k));
  endfunction

  always_comb begin
    merged = lane_value;
    for (int k = 0; k < NUM_LANES - 1; k++) begin
      if (int'(eff_size) == k)
        merged = (dst_opnd & ~lane_mask(k)) | (lane_value & lane_mask(k));
    end
  end

endmodule

// File: rtl/sized_cc_alu.sv
`timescale 1ns/1ps
module sized_cc_alu
  import sized_cc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [2:0]        quick_imm,
  input  logic              addr_dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              flag_x,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              x_we,
  output logic              n_we,
  output logic              z_we,
  output logic              v_we,
  output logic              c_we,
  output logic              illegal_op
);

  localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;

  // Named internal events, visible to the bound checker.
  logic [DATA_W-1:0] opnd_a, opnd_b, lane_value, merged_value;
  logic              do_sub, writes_result, upd_x, upd_nzvc, op_illegal;
  logic [1:0]        eff_size;
  logic              raw_c, raw_v, raw_n, raw_z;
  cc_flags_t         next_flags, flags_q;

  sized_cc_alu_decode #(.DATA_W(DATA_W)) u_decode (
    .op_sel        (op_sel),
    .size_sel      (size_sel),
    .addr_dst      (addr_dst),
    .quick_imm     (quick_imm),
    .src_opnd      (src_opnd),
    .dst_opnd      (dst_opnd),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b),
    .do_sub        (do_sub),
    .eff_size      (eff_size),
    .writes_result (writes_result),
    .upd_x         (upd_x),
    .upd_nzvc      (upd_nzvc),
    .op_illegal    (op_illegal)
  );

  sized_cc_alu_addsub #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) u_addsub (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .do_sub    (do_sub),
    .eff_size  (eff_size),
    .sum_out   (lane_value),
    .carry_out (raw_c),
    .ovf_out   (raw_v),
    .neg_out   (raw_n),
    .zero_out  (raw_z)
  );

  sized_cc_alu_merge #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) u_merge (
    .dst_opnd   (dst_opnd),
    .lane_value (lane_value),
    .eff_size   (eff_size),
    .merged     (merged_value)
  );

  assign next_flags = '{x: raw_c, n: raw_n, z: raw_z, v: raw_v, c: raw_c};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result_we  <= 1'b0;
      x_we       <= 1'b0;
      n_we       <= 1'b0;
      z_we       <= 1'b0;
      v_we       <= 1'b0;
      c_we       <= 1'b0;
      illegal_op <= 1'b0;
      result     <= '0;
      flags_q    <= '0;
    end else begin
      out_valid  <= in_valid;
      result_we  <= in_valid && writes_result;
      x_we       <= in_valid && upd_x;
      n_we       <= in_valid && upd_nzvc;
      z_we       <= in_valid && upd_nzvc;
      v_we       <= in_valid && upd_nzvc;
      c_we       <= in_valid && upd_nzvc;
      illegal_op <= in_valid && op_illegal;
      if (in_valid) begin
        result  <= merged_value;
        flags_q <= next_flags;
      end
    end
  end

  assign flag_x = flags_q.x;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;

endmodule

// File: rtl/sized_cc_alu_checker.sv
`timescale 1ns/1ps
module sized_cc_alu_checker
  import sized_cc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic [1:0]        size_sel,
  input logic [DATA_W-1:0] dst_opnd,
  input logic              addr_dst,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic              flag_x,
  input logic              flag_c,
  input logic              x_we,
  input logic              n_we,
  input logic              z_we,
  input logic              v_we,
  input logic              c_we,
  input logic              illegal_op
);

  logic any_flag_we;
  assign any_flag_we = x_we | n_we | z_we | v_we | c_we;

  a_r1_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(result_we || any_flag_we || illegal_op));

  a_r2_x_matches_c: assert property (@(posedge clk) disable iff (!rst_n)
    (x_we && c_we) |-> (flag_x == flag_c));

  a_r4_compare_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_CMP && size_sel != 2'b11) |=> (!x_we && !result_we && c_we));

  a_r9_byte_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == SZ_BYTE && (op_sel == OP_ADD || op_sel == OP_SUB))
      |=> (result_we && result[DATA_W-1:8] == $past(dst_opnd[DATA_W-1:8])));

  a_r10_addr_quick_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && addr_dst && is_quick(op_sel) && (size_sel == SZ_WORD || size_sel == SZ_LONG))
      |=> (result_we && !any_flag_we));

  a_r11_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (out_valid && !result_we && !any_flag_we));

endmodule

bind sized_cc_alu sized_cc_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .size_sel   (size_sel),
  .dst_opnd   (dst_opnd),
  .addr_dst   (addr_dst),
  .out_valid  (out_valid),
  .result     (result),
  .result_we  (result_we),
  .flag_x     (flag_x),
  .flag_c     (flag_c),
  .x_we       (x_we),
  .n_we       (n_we),
  .z_we       (z_we),
  .v_we       (v_we),
  .c_we       (c_we),
  .illegal_op (illegal_op)
);

// File: tb/sized_cc_alu_bench.sv
`timescale 1ns/1ps
module sized_cc_alu_bench;
  import sized_cc_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  size_sel = '0;
  logic [31:0] src_opnd = '0;
  logic [31:0] dst_opnd = '0;
  logic [2:0]  quick_imm = '0;
  logic        addr_dst = 1'b0;
  logic        out_valid, result_we, illegal_op;
  logic [31:0] result;
  logic        flag_x, flag_n, flag_z, flag_v, flag_c;
  logic        x_we, n_we, z_we, v_we, c_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sized_cc_alu u_sized_cc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .size_sel(size_sel),
    .src_opnd(src_opnd), .dst_opnd(dst_opnd), .quick_imm(quick_imm), .addr_dst(addr_dst),
    .out_valid(out_valid), .result(result), .result_we(result_we),
    .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .x_we(x_we), .n_we(n_we), .z_we(z_we), .v_we(v_we), .c_we(c_we), .illegal_op(illegal_op)
  );

  typedef struct {
    string       tag;
    bit          ill, we, xwe, nzvcwe;
    logic [31:0] res;
    bit          x, n, z, v, c;
  } exp_t;

  exp_t sb_q[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Reference model in wide signed integers, range-checked for overflow.
  function automatic exp_t model(logic [2:0] op, logic [1:0] sz, logic [31:0] s,
                                 logic [31:0] d, logic [2:0] q, logic ad, string tag);
    exp_t e;
    int w;
    longint one = 1;
    longint unsigned m, ua, ub, tr;
    longint sa, sbv, r;
    bit sub, quick, carry;
    e.tag = tag; e.ill = 0; e.we = 0; e.xwe = 0; e.nzvcwe = 0; e.res = '0;
    e.x = 0; e.n = 0; e.z = 0; e.v = 0; e.c = 0;
    quick = (op == 3'd4) || (op == 3'd5);
    if (sz == 2'b11 || op > 3'd5 || (quick && ad && sz == 2'b00) || (op == 3'd3 && ad)) begin
      e.ill = 1;
      return e;
    end
    w = (quick && ad) ? 32 : (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = longint'((one << w) - 1);
    ua = d; ub = s; sub = 0;
    case (op)
      3'd1, 3'd2: sub = 1;
      3'd3: begin ua = 0; ub = d; sub = 1; end
      3'd4: ub = (q == 0) ? 8 : q;
      3'd5: begin ub = (q == 0) ? 8 : q; sub = 1; end
      default: ;
    endcase
    ua &= m; ub &= m;
    sa  = ((ua >> (w-1)) & 1) ? longint'(ua) - (one << w) : longint'(ua);
    sbv = ((ub >> (w-1)) & 1) ? longint'(ub) - (one << w) : longint'(ub);
    r = sub ? sa - sbv : sa + sbv;
    carry = sub ? (ua < ub) : (((ua + ub) >> w) & 1) != 0;
    tr = longint'(r) & m;
    e.we  = (op != 3'd2);
    e.res = (d & ~m[31:0]) | tr[31:0];
    if (!(quick && ad)) begin
      e.nzvcwe = 1;
      e.xwe = (op != 3'd2);
      e.c = carry; e.x = carry;
      e.n = ((tr >> (w-1)) & 1) != 0;
      e.z = (tr == 0);
      e.v = (r > (one << (w-1)) - 1) || (r < -(one << (w-1)));
    end
    return e;
  endfunction

  task automatic drive(logic [2:0] op, logic [1:0] sz, logic [31:0] s, logic [31:0] d,
                       logic [2:0] q, logic ad, string tag);
    @(posedge clk); #1;
    in_valid = 1; op_sel = op; size_sel = sz; src_opnd = s; dst_opnd = d;
    quick_imm = q; addr_dst = ad;
    sb_q.push_back(model(op, sz, s, d, q, ad, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 0;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          chk("R1", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.tag, "illegal_op", {31'd0, illegal_op}, {31'd0, e.ill});
          chk(e.tag, "result_we",  {31'd0, result_we},  {31'd0, e.we});
          chk(e.tag, "x_we",       {31'd0, x_we},       {31'd0, e.xwe});
          chk(e.tag, "nzvc_we",    {28'd0, n_we, z_we, v_we, c_we}, {28'd0, {4{e.nzvcwe}}});
          if (e.we)     chk(e.tag, "result", result, e.res);
          if (e.xwe)    chk(e.tag, "flag_x", {31'd0, flag_x}, {31'd0, e.x});
          if (e.nzvcwe) chk(e.tag, "flags_nzvc", {28'd0, flag_n, flag_z, flag_v, flag_c},
                            {28'd0, e.n, e.z, e.v, e.c});
        end
      end else begin
        chk("R1", "strobes while idle",
            {25'd0, result_we, x_we, n_we, z_we, v_we, c_we, illegal_op}, 32'd0);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset strobes",
        {24'd0, out_valid, result_we, x_we, n_we, z_we, v_we, c_we, illegal_op}, 32'd0);
    rst_n = 1;
    idle(2);

    drive(OP_ADD,  SZ_BYTE, 32'h0000_0001, 32'hAABB_CC7F, 3'd0, 0, "R7");  // byte overflow
    drive(OP_ADD,  SZ_BYTE, 32'h0000_0001, 32'h1234_56FF, 3'd0, 0, "R8");  // carry, zero
    drive(OP_ADD,  SZ_WORD, 32'h0000_8000, 32'hFFFF_8000, 3'd0, 0, "R2");
    drive(OP_ADD,  SZ_LONG, 32'h7FFF_FFFF, 32'h0000_0001, 3'd0, 0, "R2");
    drive(OP_SUB,  SZ_BYTE, 32'h0000_0005, 32'h9999_9903, 3'd0, 0, "R3");  // borrow
    drive(OP_SUB,  SZ_LONG, 32'h0000_0001, 32'h8000_0000, 3'd0, 0, "R3");  // overflow
    drive(OP_SUB,  SZ_WORD, 32'h0000_1234, 32'hDEAD_1234, 3'd0, 0, "R9");
    drive(OP_CMP,  SZ_WORD, 32'h0000_4444, 32'h0000_4444, 3'd0, 0, "R4");
    drive(OP_CMP,  SZ_LONG, 32'h0000_0002, 32'h0000_0001, 3'd0, 0, "R4");
    drive(OP_NEG,  SZ_BYTE, 32'h0,         32'hFFFF_FF00, 3'd0, 0, "R5");  // zero operand
    drive(OP_NEG,  SZ_BYTE, 32'h0,         32'h0000_0080, 3'd0, 0, "R5");  // most negative
    drive(OP_NEG,  SZ_WORD, 32'h0,         32'h5555_0005, 3'd0, 0, "R5");
    drive(OP_QADD, SZ_BYTE, 32'h0,         32'h0000_0010, 3'd0, 0, "R6");  // code 0 = 8
    drive(OP_QSUB, SZ_LONG, 32'h0,         32'h0000_0002, 3'd3, 0, "R6");
    drive(OP_QADD, SZ_WORD, 32'h0,         32'h0000_FFFF, 3'd0, 1, "R10"); // full width
    drive(OP_QSUB, SZ_LONG, 32'h0,         32'h0000_0004, 3'd7, 1, "R10");
    drive(OP_QADD, SZ_BYTE, 32'h0,         32'h0000_0001, 3'd1, 1, "R11");
    drive(OP_NEG,  SZ_LONG, 32'h0,         32'h0000_0001, 3'd0, 1, "R11");
    drive(OP_ADD,  2'b11,   32'h1,         32'h1,         3'd0, 0, "R11");
    drive(3'd6,    SZ_LONG, 32'h1,         32'h1,         3'd0, 0, "R11");
    drive(OP_ADD,  SZ_BYTE, 32'h0000_0080, 32'h0000_0080, 3'd0, 1, "R12");
    drive(OP_CMP,  SZ_BYTE, 32'h0000_0001, 32'h0000_0080, 3'd0, 1, "R12");
    idle(3);

    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 80; i++) begin
      logic [31:0] s, d;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      s = lf;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      d = lf;
      drive(3'(s[2:0] % 3'd6), 2'(d[1:0] % 2'd3), s, d, d[6:4], (s[9:8] == 2'b11), "R7");
      if (s[12]) idle(1);
    end
    idle(4);
    chk("R1", "scoreboard drained", sb_q.size(), 32'd0);
    finish_run();
  end

endmodule